// File: doc/BRIEF.md
# TLB Access Rights and Fault Checker

This block sits directly behind a translation lookaside buffer lookup. It takes the lookup result (hit, the rights fields of the matching entry, its physical page frame) together with the current privilege level, the kind of access being attempted and the protection-id state. In the same cycle it produces the physical address, a three-bit permission mask (read, write, execute) and a four-bit fault code. A physical-mode flag bypasses translation entirely.

Permission comes from two independent sources that are ANDed. The first is a set of privilege windows derived from two per-entry bounds. The second is the grant set chosen by the entry's rights type. A nonzero access id can then be matched against four protection-id registers, and a match removes write permission. Once the requested access passes the mask, the dirty, break and reference bits may still raise a fault. A fault with capture enabled latches the virtual address, split into a low and a high word, into two report registers on the following clock edge.

Top module: `tlb_rights_chk`

## Requirements
- R1: When phys_mode is 1, paddr equals vaddr, perm_mask is 3'b111 and fault_code is 0, whatever the other inputs are.
- R2: When phys_mode is 0 and ent_hit is 0, perm_mask is 0 and fault_code is 1 for an execute access (acc_kind 2'b10) or 2 for any other access kind.
- R3: The mask bits are read at bit 0, write at bit 1 and execute at bit 2. The privilege windows are: read when priv <= ent_pl1, write when priv <= ent_pl2, execute when ent_pl2 <= priv <= ent_pl1. acc_kind encodes 2'b00 read, 2'b01 write and 2'b10 execute.
- R4: On a hit, the mask is the privilege windows ANDed with the type grant: type 0 read, type 1 read and write, type 2 read and execute, type 3 all three, types 4 to 7 execute only.
- R5: When pid_en is 1 and ent_aid is nonzero, the 32-bit value {zeros, ent_aid, 1'b1} is compared with each 32-bit slot of pid_regs (slot k at bits 32k+31:32k). On any match, mask bit 1 is cleared, and a write access gets fault_code 8.
- R6: If there is no code-8 fault and the requested access bit is clear in the mask, fault_code is 3 for execute and 4 otherwise.
- R7: With no earlier fault, the following apply in turn, each overriding the one before: ent_dirty clear on a write gives code 5, ent_brk set on a write gives code 6, and ent_ref set on a non-execute access gives code 7.
- R8: On a hit, ent_dirty clear or ent_brk set clears mask bit 1, for reads as well as writes.
- R9: On a hit, paddr is ent_pfn concatenated with vaddr[11:0].
- R10: fault_valid is 1 exactly when fault_code is nonzero.
- R11: When cap_en and fault_valid are both 1, rpt_lo takes vaddr[31:0] and rpt_hi takes vaddr[63:32] on the next clock edge. Otherwise both hold their value. Both are 0 after a synchronous reset.
- R12: acc_kind 2'b11 is treated exactly like a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the report registers |
| rst | input | 1 | Synchronous active-high reset |
| phys_mode | input | 1 | Bypass translation and checks |
| ent_hit | input | 1 | Lookup found a valid entry |
| ent_pl1 | input | 2 | Upper privilege bound of the entry |
| ent_pl2 | input | 2 | Lower privilege bound of the entry |
| ent_type | input | 3 | Rights type of the entry |
| ent_aid | input | 18 | Access id of the entry, 0 means public |
| ent_brk | input | 1 | Break-on-write bit |
| ent_dirty | input | 1 | Dirty bit |
| ent_ref | input | 1 | Reference trap bit |
| ent_pfn | input | 52 | Physical page frame number |
| priv | input | 2 | Current privilege level (0 most privileged) |
| acc_kind | input | 2 | Access kind |
| pid_en | input | 1 | Enable protection-id checking |
| pid_regs | input | 128 | Four protection-id registers |
| vaddr | input | 64 | Virtual address |
| cap_en | input | 1 | Enable fault address capture |
| paddr | output | 64 | Physical address |
| perm_mask | output | 3 | Allowed read/write/execute |
| fault_code | output | 4 | Fault code, 0 for none |
| fault_valid | output | 1 | Fault present |
| rpt_lo | output | 32 | Captured address, low word |
| rpt_hi | output | 32 | Captured address, high word |

## Verification
An exhaustive sweep covers privilege level, both bounds, every rights type and every access kind, with the modifier bits neutral. It separates errors in the window comparisons from errors in the type table, and it shows where each protection fault code appears. A second pattern walks a matching protection id through each of the four slots and adds near-misses (bit 0 clear, access id zero, checking disabled), so that any single missing comparator or a wrong match key shows up. All eight combinations of the dirty, break and reference bits are tried under each access kind, which exposes the override order and the stripping of write for reads. Miss, physical-mode and capture on/off sequences show whether the report registers latch, hold, and split the address at the right bit.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  typedef enum logic [3:0] {
    FLT_NONE    = 4'd0,
    FLT_IMISS   = 4'd1,
    FLT_DMISS   = 4'd2,
    FLT_IPROT   = 4'd3,
    FLT_DRIGHTS = 4'd4,
    FLT_DIRTY   = 4'd5,
    FLT_BREAK   = 4'd6,
    FLT_REF     = 4'd7,
    FLT_WPROT   = 4'd8
  } flt_e;

  localparam int unsigned MBIT_RD = 0;
  localparam int unsigned MBIT_WR = 1;
  localparam int unsigned MBIT_EX = 2;
endpackage

// File: rtl/tlb_rights_window.sv
module tlb_rights_window #(
  parameter int unsigned PRIV_W = 2,
  parameter int unsigned TYPE_W = 3
) (
  input  logic [PRIV_W-1:0] priv,
  input  logic [PRIV_W-1:0] pl1,
  input  logic [PRIV_W-1:0] pl2,
  input  logic [TYPE_W-1:0] atype,
  output logic [2:0]        grant
);
  logic win_r, win_w, win_x;

  assign win_r = (priv <= pl1);
  assign win_w = (priv <= pl2);
  assign win_x = (pl2 <= priv) && (priv <= pl1);

  // bit order: {execute, write, read}
  always_comb begin
    case (atype)
      TYPE_W'(0): grant = {1'b0,  1'b0,  win_r};
      TYPE_W'(1): grant = {1'b0,  win_w, win_r};
      TYPE_W'(2): grant = {win_x, 1'b0,  win_r};
      TYPE_W'(3): grant = {win_x, win_w, win_r};
      default:    grant = {win_x, 1'b0,  1'b0};
    endcase
  end
endmodule

// File: rtl/tlb_pid_match.sv
module tlb_pid_match #(
  parameter int unsigned NPID  = 4,
  parameter int unsigned PID_W = 32,
  parameter int unsigned AID_W = 18
) (
  input  logic                  en,
  input  logic [AID_W-1:0]      aid,
  input  logic [NPID*PID_W-1:0] pid_flat,
  output logic                  hit
);
  localparam int unsigned PAD_W = PID_W - AID_W - 1;

  logic [PID_W-1:0] key;
  logic [NPID-1:0]  slot_hit;

  // key has the access id shifted up by one and bit 0 forced high
  assign key = {{PAD_W{1'b0}}, aid, 1'b1};

  for (genvar g = 0; g < NPID; g++) begin : g_slot
    assign slot_hit[g] = (pid_flat[g*PID_W +: PID_W] == key);
  end

  assign hit = en && (|aid) && (|slot_hit);
endmodule

// File: rtl/tlb_fault_resolve.sv
module tlb_fault_resolve
  import tlbchk_pkg::*;
(
  input  logic       phys,
  input  logic       hit,
  input  logic [1:0] kind,
  input  logic [2:0] grant,
  input  logic       pid_hit,
  input  logic       brk,
  input  logic       dirty,
  input  logic       refb,
  output logic [2:0] mask,
  output logic [3:0] code
);
  logic       is_wr, is_ex, need;
  logic [2:0] m;

  assign is_wr = (kind == ACC_WR);
  assign is_ex = (kind == ACC_EX);

  always_comb begin
    m    = grant;
    code = FLT_NONE;
    need = 1'b0;
    if (phys) begin
      m = 3'b111;
    end else if (!hit) begin
      m    = 3'b000;
      code = is_ex ? FLT_IMISS : FLT_DMISS;
    end else begin
      if (pid_hit) m[MBIT_WR] = 1'b0;
      need = is_ex ? m[MBIT_EX] : (is_wr ? m[MBIT_WR] : m[MBIT_RD]);
      if (pid_hit && is_wr) begin
        code = FLT_WPROT;
      end else if (!need) begin
        code = is_ex ? FLT_IPROT : FLT_DRIGHTS;
      end else begin
        // later checks win over earlier ones
        if (!dirty && is_wr) code = FLT_DIRTY;
        if (brk && is_wr)    code = FLT_BREAK;
        if (refb && !is_ex)  code = FLT_REF;
      end
      if (!dirty || brk) m[MBIT_WR] = 1'b0;
    end
    mask = m;
  end
endmodule

// File: rtl/tlb_fault_capture.sv
module tlb_fault_capture #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LO_W   = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cap_en,
  input  logic                   fault,
  input  logic [ADDR_W-1:0]      addr,
  output logic [LO_W-1:0]        rpt_lo,
  output logic [ADDR_W-LO_W-1:0] rpt_hi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rpt_lo <= '0;
      rpt_hi <= '0;
    end else if (cap_en && fault) begin
      rpt_lo <= addr[LO_W-1:0];
      rpt_hi <= addr[ADDR_W-1:LO_W];
    end
  end
endmodule

// File: rtl/tlb_rights_chk.sv
module tlb_rights_chk #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned PRIV_W    = 2,
  parameter int unsigned TYPE_W    = 3,
  parameter int unsigned AID_W     = 18,
  parameter int unsigned PID_W     = 32,
  parameter int unsigned NPID      = 4,
  parameter int unsigned LO_W      = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        phys_mode,
  input  logic                        ent_hit,
  input  logic [PRIV_W-1:0]           ent_pl1,
  input  logic [PRIV_W-1:0]           ent_pl2,
  input  logic [TYPE_W-1:0]           ent_type,
  input  logic [AID_W-1:0]            ent_aid,
  input  logic                        ent_brk,
  input  logic                        ent_dirty,
  input  logic                        ent_ref,
  input  logic [ADDR_W-PAGE_BITS-1:0] ent_pfn,
  input  logic [PRIV_W-1:0]           priv,
  input  logic [1:0]                  acc_kind,
  input  logic                        pid_en,
  input  logic [NPID*PID_W-1:0]       pid_regs,
  input  logic [ADDR_W-1:0]           vaddr,
  input  logic                        cap_en,
  output logic [ADDR_W-1:0]           paddr,
  output logic [2:0]                  perm_mask,
  output logic [3:0]                  fault_code,
  output logic                        fault_valid,
  output logic [LO_W-1:0]             rpt_lo,
  output logic [ADDR_W-LO_W-1:0]      rpt_hi
);
  logic [2:0] grant;
  logic       pid_hit;

  tlb_rights_window #(.PRIV_W(PRIV_W), .TYPE_W(TYPE_W)) i_win (
    .priv (priv),
    .pl1  (ent_pl1),
    .pl2  (ent_pl2),
    .atype(ent_type),
    .grant(grant)
  );

  tlb_pid_match #(.NPID(NPID), .PID_W(PID_W), .AID_W(AID_W)) i_pid (
    .en      (pid_en),
    .aid     (ent_aid),
    .pid_flat(pid_regs),
    .hit     (pid_hit)
  );

  tlb_fault_resolve i_res (
    .phys   (phys_mode),
    .hit    (ent_hit),
    .kind   (acc_kind),
    .grant  (grant),
    .pid_hit(pid_hit),
    .brk    (ent_brk),
    .dirty  (ent_dirty),
    .refb   (ent_ref),
    .mask   (perm_mask),
    .code   (fault_code)
  );

  assign paddr       = phys_mode ? vaddr : {ent_pfn, vaddr[PAGE_BITS-1:0]};
  assign fault_valid = (fault_code != 4'd0);

  tlb_fault_capture #(.ADDR_W(ADDR_W), .LO_W(LO_W)) i_cap (
    .clk   (clk),
    .rst   (rst),
    .cap_en(cap_en),
    .fault (fault_valid),
    .addr  (vaddr),
    .rpt_lo(rpt_lo),
    .rpt_hi(rpt_hi)
  );
endmodule

// File: rtl/tlb_rights_chk_sva.sv
module tlb_rights_chk_sva #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LO_W   = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   phys_mode,
  input logic                   ent_hit,
  input logic                   ent_brk,
  input logic                   ent_dirty,
  input logic [1:0]             acc_kind,
  input logic [ADDR_W-1:0]      vaddr,
  input logic                   cap_en,
  input logic [ADDR_W-1:0]      paddr,
  input logic [2:0]             perm_mask,
  input logic [3:0]             fault_code,
  input logic                   fault_valid,
  input logic [LO_W-1:0]        rpt_lo,
  input logic [ADDR_W-LO_W-1:0] rpt_hi
);
  // R1
  phys_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    phys_mode |-> (perm_mask == 3'b111 && fault_code == 4'd0 && paddr == vaddr));

  // R2
  miss_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!phys_mode && !ent_hit) |->
      (perm_mask == 3'b000 && fault_code == ((acc_kind == 2'b10) ? 4'd1 : 4'd2)));

  // R6
  iprot_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_code == 4'd3) |-> (acc_kind == 2'b10 && !perm_mask[2]));

  // R8
  strip_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!phys_mode && ent_hit && (!ent_dirty || ent_brk)) |-> !perm_mask[1]);

  // R11
  capture_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_en && fault_valid) |=>
      (rpt_lo == $past(vaddr[LO_W-1:0]) && rpt_hi == $past(vaddr[ADDR_W-1:LO_W])));

  // R11
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cap_en && fault_valid) |=> ($stable(rpt_lo) && $stable(rpt_hi)));
endmodule

bind tlb_rights_chk tlb_rights_chk_sva #(.ADDR_W(ADDR_W), .LO_W(LO_W)) i_sva (
  .clk        (clk),
  .rst        (rst),
  .phys_mode  (phys_mode),
  .ent_hit    (ent_hit),
  .ent_brk    (ent_brk),
  .ent_dirty  (ent_dirty),
  .acc_kind   (acc_kind),
  .vaddr      (vaddr),
  .cap_en     (cap_en),
  .paddr      (paddr),
  .perm_mask  (perm_mask),
  .fault_code (fault_code),
  .fault_valid(fault_valid),
  .rpt_lo     (rpt_lo),
  .rpt_hi     (rpt_hi)
);

// File: tb/test_tlb_rights_chk.sv
module test_tlb_rights_chk;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         phys_mode, ent_hit, ent_brk, ent_dirty, ent_ref, pid_en, cap_en;
  logic [1:0]   ent_pl1, ent_pl2, priv, acc_kind;
  logic [2:0]   ent_type;
  logic [17:0]  ent_aid;
  logic [51:0]  ent_pfn;
  logic [127:0] pid_regs;
  logic [63:0]  vaddr, paddr;
  logic [2:0]   perm_mask;
  logic [3:0]   fault_code;
  logic         fault_valid;
  logic [31:0]  rpt_lo, rpt_hi;

  // shadow stimulus, copied onto the ports by the driver
  logic         s_phys, s_hit, s_brk, s_dirty, s_ref, s_pid_en, s_cap;
  logic [1:0]   s_pl1, s_pl2, s_priv, s_kind;
  logic [2:0]   s_type;
  logic [17:0]  s_aid;
  logic [51:0]  s_pfn;
  logic [127:0] s_pids;
  logic [63:0]  s_va;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [2:0]  q_mask[$];
  logic [3:0]  q_code[$];
  logic [63:0] q_pa[$];
  logic [63:0] q_va[$];
  logic        q_cap[$];
  logic        q_xlat[$];
  string       q_req[$];

  logic [31:0] exp_lo, exp_hi;

  always #(CLK_P/2) clk = ~clk;

  tlb_rights_chk i_tlb_rights_chk (
    .clk(clk), .rst(rst), .phys_mode(phys_mode), .ent_hit(ent_hit),
    .ent_pl1(ent_pl1), .ent_pl2(ent_pl2), .ent_type(ent_type), .ent_aid(ent_aid),
    .ent_brk(ent_brk), .ent_dirty(ent_dirty), .ent_ref(ent_ref), .ent_pfn(ent_pfn),
    .priv(priv), .acc_kind(acc_kind), .pid_en(pid_en), .pid_regs(pid_regs),
    .vaddr(vaddr), .cap_en(cap_en), .paddr(paddr), .perm_mask(perm_mask),
    .fault_code(fault_code), .fault_valid(fault_valid), .rpt_lo(rpt_lo), .rpt_hi(rpt_hi)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected behaviour written from the requirements
  task automatic model(output logic [2:0] m, output logic [3:0] c);
    bit ex, wr, r, w, x, pm, need;
    ex = (s_kind == 2'b10);
    wr = (s_kind == 2'b01);
    c  = 4'd0;
    if (s_phys) m = 3'b111;
    else if (!s_hit) begin
      m = 3'b000;
      c = ex ? 4'd1 : 4'd2;
    end else begin
      r = (s_priv <= s_pl1);
      w = (s_priv <= s_pl2);
      x = (s_pl2 <= s_priv) && (s_priv <= s_pl1);
      case (s_type)
        3'd0: m = {1'b0, 1'b0, r};
        3'd1: m = {1'b0, w, r};
        3'd2: m = {x, 1'b0, r};
        3'd3: m = {x, w, r};
        default: m = {x, 1'b0, 1'b0};
      endcase
      pm = 0;
      if (s_pid_en && s_aid != 0)
        for (int i = 0; i < 4; i++)
          if (s_pids[i*32 +: 32] == {13'd0, s_aid, 1'b1}) pm = 1;
      if (pm) m[1] = 1'b0;
      need = ex ? m[2] : (wr ? m[1] : m[0]);
      if (pm && wr) c = 4'd8;
      else if (!need) c = ex ? 4'd3 : 4'd4;
      else begin
        if (!s_dirty && wr) c = 4'd5;
        if (s_brk && wr)    c = 4'd6;
        if (s_ref && !ex)   c = 4'd7;
      end
      if (!s_dirty || s_brk) m[1] = 1'b0;
    end
  endtask

  // driver: one stimulus per cycle, expected item pushed to the scoreboard
  task automatic step(input string req);
    logic [2:0] m;
    logic [3:0] c;
    @(negedge clk);
    phys_mode = s_phys; ent_hit = s_hit; ent_pl1 = s_pl1; ent_pl2 = s_pl2;
    ent_type = s_type; ent_aid = s_aid; ent_brk = s_brk; ent_dirty = s_dirty;
    ent_ref = s_ref; ent_pfn = s_pfn; priv = s_priv; acc_kind = s_kind;
    pid_en = s_pid_en; pid_regs = s_pids; vaddr = s_va; cap_en = s_cap;
    model(m, c);
    q_mask.push_back(m);
    q_code.push_back(c);
    q_pa.push_back(s_phys ? s_va : {s_pfn, s_va[11:0]});
    q_va.push_back(s_va);
    q_cap.push_back(s_cap);
    q_xlat.push_back(s_phys | s_hit);
    q_req.push_back(req);
  endtask

  // monitor: compare shortly after each edge, before the driver changes inputs
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_req.size() > 0) begin
        logic [2:0]  m;
        logic [3:0]  c;
        logic [63:0] pa, va;
        logic        cp, xl;
        string       rq;
        m = q_mask.pop_front(); c = q_code.pop_front(); pa = q_pa.pop_front();
        va = q_va.pop_front(); cp = q_cap.pop_front(); xl = q_xlat.pop_front();
        rq = q_req.pop_front();
        chk(perm_mask == m, rq, "perm_mask", 64'(perm_mask), 64'(m));
        chk(fault_code == c, rq, "fault_code", 64'(fault_code), 64'(c));
        chk(fault_valid == (c != 0), "R10", "fault_valid", 64'(fault_valid), 64'(c != 0));
        if (xl) chk(paddr == pa, phys_mode ? "R1" : "R9", "paddr", paddr, pa);
        if (cp && c != 0) begin
          exp_lo = va[31:0];
          exp_hi = va[63:32];
        end
        chk(rpt_lo == exp_lo, "R11", "rpt_lo", 64'(rpt_lo), 64'(exp_lo));
        chk(rpt_hi == exp_hi, "R11", "rpt_hi", 64'(rpt_hi), 64'(exp_hi));
      end
    end
  end

  task automatic neutral();
    s_phys = 0; s_hit = 1; s_pl1 = 2'd3; s_pl2 = 2'd3; s_type = 3'd3; s_aid = '0;
    s_brk = 0; s_dirty = 1; s_ref = 0; s_pfn = 52'h0_0000_0ABC_D123; s_priv = 2'd0;
    s_kind = 2'b00; s_pid_en = 0; s_pids = '0; s_va = 64'h0000_1111_2222_3456; s_cap = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    exp_lo = '0; exp_hi = '0;
    neutral();
    s_cap = 1; s_hit = 0;
    phys_mode = s_phys; ent_hit = s_hit; ent_pl1 = s_pl1; ent_pl2 = s_pl2;
    ent_type = s_type; ent_aid = s_aid; ent_brk = s_brk; ent_dirty = s_dirty;
    ent_ref = s_ref; ent_pfn = s_pfn; priv = s_priv; acc_kind = s_kind;
    pid_en = s_pid_en; pid_regs = s_pids; vaddr = 64'hDEAD_BEEF_CAFE_F00D; cap_en = 1;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state even with a pending fault and capture enabled
    chk(rpt_lo == 0, "R11", "reset rpt_lo", 64'(rpt_lo), 64'd0);
    chk(rpt_hi == 0, "R11", "reset rpt_hi", 64'(rpt_hi), 64'd0);
    @(negedge clk);
    cap_en = 0;
    rst = 0;

    // R1 physical mode with hostile entry fields
    neutral();
    s_phys = 1; s_hit = 0; s_brk = 1; s_dirty = 0; s_ref = 1; s_type = 3'd0;
    s_cap = 1;
    for (int k = 0; k < 4; k++) begin
      s_kind = 2'(k);
      s_va = 64'hFEDC_BA98_7654_3210 ^ 64'(k * 64'h1_0001_0001);
      step("R1");
    end

    // R2 misses, with capture on then off (R11)
    neutral();
    s_hit = 0; s_cap = 1;
    s_kind = 2'b10; s_va = 64'h0123_4567_89AB_CDEF; step("R2");
    s_kind = 2'b00; s_va = 64'h1357_9BDF_0246_8ACE; step("R2");
    s_kind = 2'b01; s_cap = 0; s_va = 64'hAAAA_5555_AAAA_5555; step("R2");
    s_cap = 1; s_hit = 1; s_va = 64'h7777_0000_8888_0000; step("R11");

    // R3 R4 R6 exhaustive window and type sweep
    neutral();
    for (int t = 0; t < 8; t++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int p = 0; p < 4; p++)
            for (int k = 0; k < 3; k++) begin
              s_type = 3'(t); s_pl1 = 2'(a); s_pl2 = 2'(b); s_priv = 2'(p); s_kind = 2'(k);
              s_va = {32'(t * 256 + a * 16 + b), 32'(p * 4 + k)};
              s_cap = (k == 2);
              step("R3 R4 R6");
            end

    // R12 reserved access kind behaves as read
    neutral();
    s_kind = 2'b11;
    for (int t = 0; t < 8; t++) begin
      s_type = 3'(t); s_priv = 2'd1; s_pl1 = 2'd2; s_pl2 = 2'd0;
      step("R12");
    end
    s_type = 3'd3; s_ref = 1; step("R12");

    // R5 protection-id match in each slot, plus near misses
    neutral();
    s_pid_en = 1; s_aid = 18'h2_5A5A;
    for (int sl = 0; sl < 4; sl++) begin
      s_pids = {4{32'hFFFF_0000}};
      s_pids[sl*32 +: 32] = {13'd0, s_aid, 1'b1};
      s_kind = 2'b00; step("R5");
      s_kind = 2'b01; step("R5");
      s_kind = 2'b10; step("R5");
    end
    s_pids = {4{13'd0, s_aid, 1'b0}}; s_kind = 2'b01; step("R5");
    s_pids[63:32] = {13'd0, s_aid, 1'b1}; s_pid_en = 0; step("R5");
    s_pid_en = 1; s_aid = '0; s_pids = {4{32'h1}}; step("R5");
    s_aid = 18'h2_5A5A; s_pids[63:32] = {13'd0, s_aid, 1'b1};
    s_dirty = 0; s_ref = 1; step("R5");

    // R7 R8 dirty, break, reference override order
    neutral();
    for (int v = 0; v < 8; v++)
      for (int k = 0; k < 3; k++) begin
        s_dirty = v[0]; s_brk = v[1]; s_ref = v[2]; s_kind = 2'(k);
        s_cap = 1; s_va = {32'(v), 32'(k) << 20};
        step("R7 R8");
      end

    // R9 physical address composition
    neutral();
    s_pfn = 52'hF_FFFF_FFFF_FFFF; s_va = 64'h0000_0000_0000_0FFF; step("R9");
    s_pfn = 52'h0; s_va = 64'hFFFF_FFFF_FFFF_F123; step("R9");
    s_pfn = 52'h5_A5A5_A5A5_A5A5; s_va = 64'h1234_5678_9ABC_D800; step("R9");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule